// File: doc/BRIEF.md
# Burst-of-Two Common-I/O DDR SRAM Controller

This block sits on the host side of a double-data-rate SRAM whose data pins are shared by reads and writes. Every command to the memory moves a fixed pair of data beats. The user side is a valid/ready request port and a response strobe. A request carries an address, a write flag and two data words. A read returns its two words on a one-slot response strobe.

The controller runs on a slot clock at twice the memory clock rate, so each slot is one half of a memory clock period. The output `memKRise` is high in the slots that line up with a rising edge of the memory clock. Commands are issued only in those slots.

- Write data is late: it goes out in the two slots that follow the command.
- Read data comes back after a read latency, given as a parameter counted in slots. A delay line of flags in the controller tracks when each read beat arrives.
- Commands in the same direction are streamed with no gap.
- When a write follows a read, the controller holds the write back. Its data may reach the bus only once the last read beat has passed and one further idle slot has gone by.

Top module: `b2s_sram_ctrl`

## Requirements
- R1: A command is shown on the memory pins as `memLoadN` low for exactly one slot, and only in a slot where `memKRise` is 1. In every other slot `memLoadN` is 1.
- R2: A request accepted at the end of slot t appears on the pins in slot t+1 with its address on `memAddr`. `memReadWrite` is 1 for a read and 0 for a write.
- R3: For a write command in slot c, `reqData0` is driven on `memDqOut` in slot c+1 and `reqData1` in slot c+2. `memDqOe` is 1 in exactly those write-beat slots and 0 in all others.
- R4: For a read command in slot c, the controller samples `memDqIn` in slots c+RD_LAT (first beat) and c+RD_LAT+1 (second beat). In slot c+RD_LAT+2 it raises `rspValid` for one slot, with the first beat on `rspData0` and the second on `rspData1`.
- R5: A write command that follows a read command in slot c is issued no earlier than slot c+RD_LAT+2. The memory and the controller never drive the bus in the same slot.
- R6: When requests are held continuously valid, consecutive commands are spaced 2 slots apart for read→read, write→write and write→read. Read→write is spaced by the smallest even number of slots that is at least RD_LAT+2.
- R7: `reqReady` is 0 in every slot where `memKRise` is 1. It is also 0 for a write request while an earlier read could still collide with that write's data on the bus.
- R8: Each read returns the two words most recently written to its address, and responses come back in request order.
- R9: During and right after reset, `memLoadN` is 1, `memDqOe` is 0 and `rspValid` is 0. The first slot after reset has `memKRise` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken at the end of this slot when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Burst address |
| reqData0 | input | DATA_W | First write word |
| reqData1 | input | DATA_W | Second write word |
| rspValid | output | 1 | Read response strobe, one slot |
| rspData0 | output | DATA_W | First read word |
| rspData1 | output | DATA_W | Second read word |
| memKRise | output | 1 | High in slots aligned with a rising edge of the memory clock |
| memLoadN | output | 1 | Active-low command load |
| memReadWrite | output | 1 | 1 = read, 0 = write |
| memAddr | output | ADDR_W | Command address |
| memDqOut | output | DATA_W | Write data toward the shared bus |
| memDqOe | output | 1 | Drive enable for `memDqOut` |
| memDqIn | input | DATA_W | Data from the shared bus |

## Verification
The bench builds the block with a 4-bit address and 16-bit words, and keeps the default read latency of 5 slots. With only 16 bursts, it can write and read back every address. It can also run all four direction pairs back-to-back on every address before starting mixed pseudo-random traffic. An odd latency puts the read beats off the command phase, so the read→write spacing rounds up to 8 slots, and the bench checks that exact boundary on every read-to-write change.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
  // Strobes from the sequencer to the datapath, all qualified to the current slot
  typedef struct packed {
    logic loadCmd;     // register a command onto the pins for the next slot
    logic cmdWrite;    // that command is a write
    logic driveEn;     // drive a write beat in the next slot
    logic driveFirst;  // the beat to drive is the first one
    logic capFirst;    // memory drives the first read beat in this slot
    logic capLast;     // memory drives the second read beat in this slot
  } strobe_t;
endpackage

// File: rtl/b2s_ctrl.sv
module b2s_ctrl
  import b2s_pkg::*;
#(
  parameter int RD_LAT = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    kRise,
  output strobe_t st
);
  localparam int AGE_W = RD_LAT + 2;

  logic             phase;
  logic [1:0]       wrAge;
  logic [AGE_W-1:0] rdAge;
  logic             readBusy;
  logic             accept;

  // A write may not start while any read could still own the bus in its beat slot
  assign readBusy = |rdAge[RD_LAT:0];
  assign kRise    = ~phase;
  assign reqReady = phase & ~(reqWrite & readBusy);
  assign accept   = reqValid & reqReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      wrAge <= '0;
      rdAge <= '0;
    end else begin
      phase <= ~phase;
      wrAge <= {wrAge[0], accept & reqWrite};
      rdAge <= {rdAge[AGE_W-2:0], accept & ~reqWrite};
    end
  end

  always_comb begin
    st.loadCmd    = accept;
    st.cmdWrite   = reqWrite;
    st.driveEn    = |wrAge;
    st.driveFirst = wrAge[0];
    st.capFirst   = rdAge[RD_LAT];
    st.capLast    = rdAge[RD_LAT+1];
  end

  // R5
  wr_after_rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (|wrAge) |-> (rdAge[AGE_W-1:RD_LAT-1] == '0));

  // R1
  cmd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (rdAge[0] | wrAge[0]) |-> kRise);
endmodule

// File: rtl/b2s_datapath.sv
module b2s_datapath
  import b2s_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData0,
  input  logic [DATA_W-1:0] reqData1,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memLoadN,
  output logic              memReadWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData0,
  output logic [DATA_W-1:0] rspData1
);
  logic [DATA_W-1:0] wrWord0, wrWord1, rdWord0;

  always_ff @(posedge clk) begin
    if (rst) begin
      memLoadN     <= 1'b1;
      memReadWrite <= 1'b1;
      memAddr      <= '0;
      memDqOut     <= '0;
      memDqOe      <= 1'b0;
      wrWord0      <= '0;
      wrWord1      <= '0;
      rdWord0      <= '0;
      rspValid     <= 1'b0;
      rspData0     <= '0;
      rspData1     <= '0;
    end else begin
      memLoadN <= ~st.loadCmd;
      if (st.loadCmd) begin
        memReadWrite <= ~st.cmdWrite;
        memAddr      <= reqAddr;
        if (st.cmdWrite) begin
          wrWord0 <= reqData0;
          wrWord1 <= reqData1;
        end
      end
      memDqOe <= st.driveEn;
      if (st.driveEn) memDqOut <= st.driveFirst ? wrWord0 : wrWord1;
      if (st.capFirst) rdWord0 <= memDqIn;
      rspValid <= st.capLast;
      if (st.capLast) begin
        rspData0 <= rdWord0;
        rspData1 <= memDqIn;
      end
    end
  end

  // R4
  rsp_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);
endmodule

// File: rtl/b2s_sram_ctrl.sv
module b2s_sram_ctrl
  import b2s_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData0,
  input  logic [DATA_W-1:0] reqData1,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData0,
  output logic [DATA_W-1:0] rspData1,
  output logic              memKRise,
  output logic              memLoadN,
  output logic              memReadWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);
  strobe_t st;

  b2s_ctrl #(.RD_LAT(RD_LAT)) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .kRise(memKRise), .st(st)
  );

  b2s_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .st(st), .reqAddr(reqAddr),
    .reqData0(reqData0), .reqData1(reqData1), .memDqIn(memDqIn),
    .memLoadN(memLoadN), .memReadWrite(memReadWrite), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .rspValid(rspValid),
    .rspData0(rspData0), .rspData1(rspData1)
  );

  // R1
  cmd_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !memLoadN |-> memKRise);

  // R1
  cmd_one_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !memLoadN |=> memLoadN);

  // R2
  wr_cmd_encode_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqWrite) |=> (!memLoadN && !memReadWrite));

  // R3
  oe_window_chk: assert property (@(posedge clk) disable iff (rst)
    memDqOe |-> (($past(!memLoadN && !memReadWrite)) ||
                 ($past(!memLoadN && !memReadWrite, 2))));

  // R7
  ready_phase_chk: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> !memKRise);
endmodule

// File: tb/sim_b2s_sram_ctrl.sv
module sim_b2s_sram_ctrl;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LAT = 5;
  localparam int TA = ((LAT + 3) / 2) * 2;
  localparam int NA = 1 << AW;

  logic clk = 0, rst = 1;
  logic reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData0 = '0, reqData1 = '0, memDqIn = '0;
  logic reqReady, rspValid, memKRise, memLoadN, memReadWrite, memDqOe;
  logic [DW-1:0] rspData0, rspData1, memDqOut;
  logic [AW-1:0] memAddr;

  always #2.5 clk = ~clk;

  b2s_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData0(reqData0),
    .reqData1(reqData1), .rspValid(rspValid), .rspData0(rspData0),
    .rspData1(rspData1), .memKRise(memKRise), .memLoadN(memLoadN),
    .memReadWrite(memReadWrite), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0, errors = 0, slotNow = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    slotNow <= slotNow + 1;
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference memory and expectation queues
  logic [DW-1:0] ref0 [NA], ref1 [NA], sm0 [NA], sm1 [NA];
  logic cqW [64]; logic [AW-1:0] cqA [64]; int cqS [64];
  logic [DW-1:0] rq0 [64], rq1 [64];
  int cqHead = 0, cqTail = 0, rqHead = 0, rqTail = 0;
  bit havePrev = 0, prevW = 0; int prevSlot = 0;

  // memory model schedules, indexed by slot modulo 16
  bit rdV [16]; logic [DW-1:0] rdD [16];
  bit wrV [16]; logic [AW-1:0] wrA [16]; bit wrB [16];
  bit rspE [16];
  int lastRd = -1000;

  initial begin
    for (int i = 0; i < NA; i++) begin ref0[i] = 0; ref1[i] = 0; sm0[i] = 0; sm1[i] = 0; end
    for (int i = 0; i < 16; i++) begin rdV[i] = 0; wrV[i] = 0; rspE[i] = 0; end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int k; bit drv;
      k = slotNow % 16;
      drv = rdV[k];
      if (drv) begin memDqIn = rdD[k]; rdV[k] = 0; end
      else memDqIn = '0;
      if (drv) chk(!memDqOe, "R5 bus conflict", memDqOe, 0);
      if (wrV[k]) begin
        chk(memDqOe, "R3 write beat enable", memDqOe, 1);
        if (wrB[k]) sm1[wrA[k]] = memDqOut; else sm0[wrA[k]] = memDqOut;
        wrV[k] = 0;
      end else if (memDqOe) chk(0, "R3 stray drive", 1, 0);
      if (rspE[k]) begin
        chk(rspValid, "R4 response timing", rspValid, 1);
        chk(rspData0 == rq0[rqHead % 64], "R8 first word", rspData0, rq0[rqHead % 64]);
        chk(rspData1 == rq1[rqHead % 64], "R8 second word", rspData1, rq1[rqHead % 64]);
        rqHead++; rspE[k] = 0;
      end else if (rspValid) chk(0, "R4 stray response", 1, 0);
      if (reqReady && memKRise) chk(0, "R7 ready on rise slot", 1, 0);
      if (!memLoadN) begin
        chk(memKRise, "R1 command phase", memKRise, 1);
        if (cqHead == cqTail) chk(0, "R2 unexpected command", 1, 0);
        else begin
          chk(memReadWrite == !cqW[cqHead % 64], "R2 direction", memReadWrite, !cqW[cqHead % 64]);
          chk(memAddr == cqA[cqHead % 64], "R2 address", memAddr, cqA[cqHead % 64]);
          chk(slotNow == cqS[cqHead % 64], "R2 command slot", slotNow, cqS[cqHead % 64]);
          cqHead++;
        end
        if (memReadWrite) begin
          rdV[(slotNow + LAT) % 16] = 1;     rdD[(slotNow + LAT) % 16] = sm0[memAddr];
          rdV[(slotNow + LAT + 1) % 16] = 1; rdD[(slotNow + LAT + 1) % 16] = sm1[memAddr];
          rspE[(slotNow + LAT + 2) % 16] = 1;
          lastRd = slotNow;
        end else begin
          chk(slotNow - lastRd >= LAT + 2, "R5 turnaround", slotNow - lastRd, LAT + 2);
          wrV[(slotNow + 1) % 16] = 1; wrA[(slotNow + 1) % 16] = memAddr; wrB[(slotNow + 1) % 16] = 0;
          wrV[(slotNow + 2) % 16] = 1; wrA[(slotNow + 2) % 16] = memAddr; wrB[(slotNow + 2) % 16] = 1;
        end
      end
    end
  end

  task automatic sendReq(input bit w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqAddr = a; reqData0 = d0; reqData1 = d1;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    if (havePrev) begin
      int expGap;
      expGap = (!prevW && w) ? TA : 2;
      chk(slotNow - prevSlot == expGap, (!prevW && w) ? "R6 read-write spacing" : "R6 stream spacing",
          slotNow - prevSlot, expGap);
    end
    havePrev = 1; prevW = w; prevSlot = slotNow;
    cqW[cqTail % 64] = w; cqA[cqTail % 64] = a; cqS[cqTail % 64] = slotNow + 1; cqTail++;
    if (w) begin ref0[a] = d0; ref1[a] = d1; end
    else begin rq0[rqTail % 64] = ref0[a]; rq1[rqTail % 64] = ref1[a]; rqTail++; end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = 0;
    havePrev = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R9
    chk(memLoadN, "R9 load idle", memLoadN, 1);
    chk(!memDqOe, "R9 drive off", memDqOe, 0);
    chk(!rspValid, "R9 no response", rspValid, 0);
    chk(memKRise, "R9 first phase", memKRise, 1);

    // write every address back-to-back, then read every address back-to-back
    for (int a = 0; a < NA; a++) sendReq(1, a[AW-1:0], DW'(a * 257 + 1), DW'(16'hF0F0 ^ a));
    for (int a = 0; a < NA; a++) sendReq(0, a[AW-1:0], '0, '0);
    idle(12);

    // every direction pair on every address, streamed
    for (int a = 0; a < NA; a++) begin
      for (int p = 0; p < 4; p++) begin
        step(); sendReq(p[1], a[AW-1:0], lfsr, ~lfsr);
        step(); sendReq(p[0], a[AW-1:0], lfsr ^ 16'h5A5A, lfsr + 16'd3);
      end
    end
    idle(12);

    // mixed pseudo-random traffic with occasional idles
    for (int i = 0; i < 800; i++) begin
      step();
      if (lfsr[9:8] == 2'b00) idle(1 + lfsr[2:0]);
      step();
      sendReq(lfsr[0], lfsr[AW+1:2], lfsr ^ 16'h1234, {lfsr[7:0], lfsr[15:8]});
    end
    idle(30);
    // R8
    chk(rqHead == rqTail, "R8 all reads returned", rqHead, rqTail);
    chk(cqHead == cqTail, "R2 all commands seen", cqHead, cqTail);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule